// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Target

This block is the target side of a Microwire-style serial memory: 1024 words of 16 bits behind a chip-select, a serial clock, a serial data input and a data output with an enable. The serial pins are sampled in a fast system clock domain, and a serial-clock rising edge is found by comparison with the previous sample. A frame opens with a start bit, which may follow any number of zero dummy clocks. Next come a two-bit opcode and ten address bits. A read then streams words out, and the address advances after each word. A write-class frame gathers sixteen data bits and hands a decoded command to a small write controller when select falls.

Writes are refused until an enable command has arrived, and the block comes out of reset with writes refused. Every write-class command is checked against its exact clock count: a frame that ends early or carries extra clocks is dropped. The storage is a register array that every reset returns to all ones.

Top module: `mw_target`

## Requirements
- R1: After reset every word reads FFFFh, the data output is not enabled, and writes are disabled.
- R2: Serial clock and data are sampled only on a serial-clock rising edge seen while select is high. Clock and data activity while select is low has no effect.
- R3: Rising edges with data-in low before the first high bit are dummy clocks and are discarded. The first high bit is the start bit.
- R4: After the start bit come two opcode bits, then ten address bits, most significant first. Opcode 10 is a read, 01 a write, 11 an erase and 00 an extended command.
- R5: On a read, the output is enabled and drives 0 right after the edge that latches the last address bit. On each following rising edge it presents the next of the 16 data bits, most significant first.
- R6: While select stays high, each finished read word is followed by the word at the next address, and address 1023 is followed by address 0.
- R7: The data output is not enabled whenever select is low.
- R8: For an extended command, address bits 9:8 choose the action: 11 enables writes, 00 disables writes, 01 writes all words, 10 erases all words. Enable and disable take effect once all 13 frame bits have arrived.
- R9: A write of 29 frame bits (start, opcode, address, data) stores its data word at its address when select falls, but only while writes are enabled.
- R10: An erase of exactly 13 frame bits sets its addressed word to FFFFh at select fall, when writes are enabled.
- R11: A write-all of exactly 29 bits fills every word with its data, and an erase-all of exactly 13 bits fills every word with FFFFh, when writes are enabled.
- R12: A write-class frame with fewer or more clocks than its exact count changes no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, high while a frame is active |
| sk | input | 1 | Serial clock, synchronous to clk and sampled on it |
| di | input | 1 | Serial data input |
| do_data | output | 1 | Serial data output value |
| do_oe | output | 1 | Output enable; low means the data pin is high impedance |

## Verification
The bench aims at off-by-one clock counts. It sends write, erase and fill frames one clock short and one clock long, so a design that commits a partial or overrun frame would leave a corrupted word where the model still holds the old value. Sequential reads are started at addresses 1022 and 1023 to catch a missing wrap. The first data bit after the address is checked for the forced zero, which catches a stream shifted by one bit. Dummy-clock prefixes and serial-clock toggling with select low are mixed into the stream, so a parser that starts a frame too early would misread the opcode.

// File: rtl/mw_pkg.sv
// Shared encodings for the serial word memory target.
// Assumes a two-bit opcode and a two-bit extended sub-code taken from the
// top address bits.
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA
    } mw_state_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WRITE,
        CMD_ERASE,
        CMD_WRALL,
        CMD_ERALL,
        CMD_WEN,
        CMD_WDIS
    } mw_cmd_t;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] EXT_WDIS  = 2'b00;
    localparam logic [1:0] EXT_WRALL = 2'b01;
    localparam logic [1:0] EXT_ERALL = 2'b10;
    localparam logic [1:0] EXT_WEN   = 2'b11;

endpackage

// File: rtl/mw_sample.sv
// Pin sampler: finds serial-clock rising edges and the end of a frame.
// Assumes cs and sk are already synchronous to clk.
module mw_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    output logic bit_stb,
    output logic frame_end
);

    logic sk_q;
    logic cs_q;

    // Hold the previous sample of the serial clock and of select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sk;
            cs_q <= cs;
        end
    end

    // A bit counts only on a rising edge while select is high.
    always_comb begin
        bit_stb   = cs & sk & ~sk_q;
        frame_end = cs_q & ~cs;
    end

endmodule

// File: rtl/mw_frame.sv
// Frame parser: start bit, opcode, address, then a read stream or write data.
// Assumes bit_stb pulses once per serial-clock rise while select is high.
// At select fall it presents a one-cycle command when the frame count fits.
module mw_frame #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs,
    input  logic                  di,
    input  logic                  bit_stb,
    input  logic                  frame_end,
    input  logic [DATA_W-1:0]     rd_word,
    output logic [ADDR_W-1:0]     rd_addr,
    output logic                  do_data,
    output logic                  do_oe,
    output logic                  cmd_valid,
    output mw_pkg::mw_cmd_t       cmd_kind,
    output logic [ADDR_W-1:0]     cmd_addr,
    output logic [DATA_W-1:0]     cmd_data
);
    import mw_pkg::*;

    localparam int SHORT_LEN = 3 + ADDR_W;
    localparam int LONG_LEN  = SHORT_LEN + DATA_W;
    localparam int CNT_W     = $clog2(LONG_LEN + 2);
    localparam int IDX_W     = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};

    mw_state_t          state;
    logic [CNT_W-1:0]   cnt;
    logic [1:0]         op;
    logic [ADDR_W-1:0]  addr;
    logic [DATA_W-1:0]  wsh;
    logic [IDX_W-1:0]   bit_idx;
    logic               do_q;
    logic               oe_q;
    mw_cmd_t            kind_n;
    logic [1:0]         sub;

    assign sub = addr[ADDR_W-1 -: 2];

    // Parse the serial frame one bit per serial-clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            op      <= '0;
            addr    <= '0;
            wsh     <= '0;
            bit_idx <= '0;
            do_q    <= 1'b0;
            oe_q    <= 1'b0;
        end else if (!cs) begin
            state <= ST_IDLE;
            cnt   <= '0;
            oe_q  <= 1'b0;
        end else if (bit_stb) begin
            if (state == ST_IDLE) begin
                if (di) begin
                    state <= ST_OPC;
                    cnt   <= CNT_W'(1);
                end
            end else begin
                if (cnt != CNT_FULL) begin
                    cnt <= cnt + 1'b1;
                end
                case (state)
                    ST_OPC: begin
                        op <= {op[0], di};
                        if (cnt == CNT_W'(2)) begin
                            state <= ST_ADDR;
                        end
                    end
                    ST_ADDR: begin
                        addr <= {addr[ADDR_W-2:0], di};
                        if (cnt == CNT_W'(SHORT_LEN - 1)) begin
                            if (op == OP_READ) begin
                                state   <= ST_RDATA;
                                oe_q    <= 1'b1;
                                do_q    <= 1'b0;
                                bit_idx <= '0;
                            end else begin
                                state <= ST_WDATA;
                            end
                        end
                    end
                    ST_RDATA: begin
                        do_q <= rd_word[IDX_W'(DATA_W - 1) - bit_idx];
                        if (bit_idx == IDX_W'(DATA_W - 1)) begin
                            bit_idx <= '0;
                            addr    <= addr + 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    ST_WDATA: begin
                        wsh <= {wsh[DATA_W-2:0], di};
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Decide which command a frame ending now would carry, by exact count.
    always_comb begin
        kind_n = CMD_NONE;
        if (state == ST_WDATA) begin
            case (op)
                OP_WRITE: if (cnt == CNT_W'(LONG_LEN))  kind_n = CMD_WRITE;
                OP_ERASE: if (cnt == CNT_W'(SHORT_LEN)) kind_n = CMD_ERASE;
                OP_EXT: begin
                    case (sub)
                        EXT_WEN:   kind_n = CMD_WEN;
                        EXT_WDIS:  kind_n = CMD_WDIS;
                        EXT_WRALL: if (cnt == CNT_W'(LONG_LEN))  kind_n = CMD_WRALL;
                        default:   if (cnt == CNT_W'(SHORT_LEN)) kind_n = CMD_ERALL;
                    endcase
                end
                default: kind_n = CMD_NONE;
            endcase
        end
    end

    // Register the decoded command on the select fall that closes the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_kind  <= CMD_NONE;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= frame_end && (kind_n != CMD_NONE);
            cmd_kind  <= kind_n;
            cmd_addr  <= addr;
            cmd_data  <= wsh;
        end
    end

    // Output pin: driven only during a read with select high.
    always_comb begin
        rd_addr = addr;
        do_oe   = oe_q & cs;
        do_data = do_q & do_oe;
    end

endmodule

// File: rtl/mw_wrctl.sv
// Write controller: holds the write-enable latch and turns accepted commands
// into array write strobes. Assumes cmd_valid is a one-cycle pulse.
module mw_wrctl #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  mw_pkg::mw_cmd_t   cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              we_one,
    output logic              we_all,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    import mw_pkg::*;

    logic wen_q;

    // Track the write-enable latch; writes are refused out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q <= 1'b0;
        end else if (cmd_valid && cmd_kind == CMD_WEN) begin
            wen_q <= 1'b1;
        end else if (cmd_valid && cmd_kind == CMD_WDIS) begin
            wen_q <= 1'b0;
        end
    end

    // Map a command to one strobe plus the data it writes.
    always_comb begin
        we_one  = cmd_valid && wen_q && (cmd_kind == CMD_WRITE || cmd_kind == CMD_ERASE);
        we_all  = cmd_valid && wen_q && (cmd_kind == CMD_WRALL || cmd_kind == CMD_ERALL);
        wr_addr = cmd_addr;
        wr_data = (cmd_kind == CMD_ERASE || cmd_kind == CMD_ERALL) ? '1 : cmd_data;
    end

endmodule

// File: rtl/mw_array.sv
// Word storage: register array with one addressed write port, a fill port
// and a combinational read port. Reset returns every word to all ones.
module mw_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_one,
    input  logic              we_all,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Update storage: reset fill, whole-array fill, or one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (we_all) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= wr_data;
            end
        end else if (we_one) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read the addressed word without delay.
    always_comb begin
        rd_data = mem[rd_addr];
    end

endmodule

// File: rtl/mw_target.sv
// Top of the serial word memory target: sampler, frame parser, write
// controller and storage. Assumes serial pins are synchronous to clk and
// that the serial clock runs well below clk.
module mw_target #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_data,
    output logic do_oe
);
    import mw_pkg::*;

    logic              bit_stb;
    logic              frame_end;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_word;
    logic              cmd_valid;
    mw_cmd_t           cmd_kind;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              we_one;
    logic              we_all;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    mw_sample u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .sk        (sk),
        .bit_stb   (bit_stb),
        .frame_end (frame_end)
    );

    mw_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .di        (di),
        .bit_stb   (bit_stb),
        .frame_end (frame_end),
        .rd_word   (rd_word),
        .rd_addr   (rd_addr),
        .do_data   (do_data),
        .do_oe     (do_oe),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data)
    );

    mw_wrctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wrc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .we_one    (we_one),
        .we_all    (we_all),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_one  (we_one),
        .we_all  (we_all),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

endmodule

// File: rtl/mw_target_chk.sv
// Checker for the serial word memory target, bound to every instance.
module mw_target_chk (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic do_data,
    input logic do_oe,
    input logic bit_stb,
    input logic we_one,
    input logic we_all
);

    // R7: output released whenever select is low
    a_r7_released_when_deselected: assert property (
        @(posedge clk) disable iff (!rst_n) !cs |-> !do_oe);

    // R5: the first driven value of a read is the leading zero
    a_r5_leading_zero: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(do_oe) |-> !do_data);

    // R5: while driven, the output moves only after a serial-clock rise
    a_r5_moves_on_rise: assert property (
        @(posedge clk) disable iff (!rst_n)
        (do_oe && $past(do_oe) && !$stable(do_data)) |-> $past(bit_stb));

    // R9: storage is written only after select has fallen
    a_r9_commit_deselected: assert property (
        @(posedge clk) disable iff (!rst_n) (we_one || we_all) |-> !cs);

    // R11: a fill never coincides with a single-word write
    a_r11_one_strobe: assert property (
        @(posedge clk) disable iff (!rst_n) $onehot0({we_one, we_all}));

endmodule

bind mw_target mw_target_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .do_data (do_data),
    .do_oe   (do_oe),
    .bit_stb (bit_stb),
    .we_one  (we_one),
    .we_all  (we_all)
);

// File: tb/mw_target_test.sv
// Bench for the serial word memory target: directed corners plus seeded
// random frames, checked against a word-level model kept in the bench.
module mw_target_test;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic cs    = 1'b0;
    logic sk    = 1'b0;
    logic di    = 1'b0;
    logic do_data;
    logic do_oe;

    logic [15:0] mdl [1024];
    bit          mwen;
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #5 clk = ~clk;

    mw_target uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sk      (sk),
        .di      (di),
        .do_data (do_data),
        .do_oe   (do_oe)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        cs = 1'b1;
        clks(2);
    endtask

    task automatic desel();
        di = 1'b0;
        clks(2);
        cs = 1'b0;
        clks(4);
    endtask

    task automatic bit_out(logic b);
        di = b;
        clks(3);
        sk = 1'b1;
        clks(3);
        sk = 1'b0;
        clks(1);
    endtask

    task automatic read_pulse(output logic b);
        di = 1'b0;
        clks(3);
        sk = 1'b1;
        clks(3);
        b  = do_data;
        sk = 1'b0;
        clks(1);
    endtask

    // Model of the command rules: exact counts and the enable latch.
    task automatic apply(logic [1:0] op, logic [9:0] a, logic [15:0] d, int n);
        case (op)
            2'b01: if (n == 29 && mwen) mdl[a] = d;
            2'b11: if (n == 13 && mwen) mdl[a] = 16'hFFFF;
            2'b00: begin
                case (a[9:8])
                    2'b11: if (n >= 13) mwen = 1'b1;
                    2'b00: if (n >= 13) mwen = 1'b0;
                    2'b01: if (n == 29 && mwen) for (int i = 0; i < 1024; i++) mdl[i] = d;
                    default: if (n == 13 && mwen) for (int i = 0; i < 1024; i++) mdl[i] = 16'hFFFF;
                endcase
            end
            default: ;
        endcase
    endtask

    // Send a non-read frame with dummies, n bits counted from the start bit.
    task automatic frame(int dum, logic [1:0] op, logic [9:0] a, logic [15:0] d, int n);
        logic [28:0] v;
        v = {1'b1, op, a, d};
        sel();
        repeat (dum) bit_out(1'b0);
        for (int i = 0; i < n; i++) bit_out(i < 29 ? v[28 - i] : 1'b0);
        desel();
        apply(op, a, d, n);
    endtask

    task automatic rd(int dum, logic [9:0] a, int nw, string req);
        logic [15:0] w;
        logic        b;
        sel();
        repeat (dum) bit_out(1'b0);
        bit_out(1'b1);
        bit_out(1'b1);
        bit_out(1'b0);
        for (int i = 9; i >= 0; i--) bit_out(a[i]);
        check("R5 leading zero", {30'd0, do_oe, do_data}, 32'd2);
        for (int k = 0; k < nw; k++) begin
            for (int i = 15; i >= 0; i--) begin
                read_pulse(b);
                w[i] = b;
            end
            check(req, {16'd0, w}, {16'd0, mdl[(int'(a) + k) % 1024]});
        end
        desel();
        check("R7 released after read", {31'd0, do_oe}, 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [9:0]  ra;
        logic [15:0] rdv;
        int          kind;
        int          n;
        void'($urandom(32'h0000_5eed));
        for (int i = 0; i < 1024; i++) mdl[i] = 16'hFFFF;
        mwen = 1'b0;
        clks(4);
        rst_n = 1'b1;
        clks(2);

        // R1: reset state
        check("R1 output disabled", {31'd0, do_oe}, 32'd0);
        rd(0, 10'd0, 1, "R1 reset content");
        // R6: wrap at the top address
        rd(0, 10'd1022, 3, "R6 sequential wrap");

        // R8: write refused while disabled (R1 default)
        frame(0, 2'b01, 10'd5, 16'h1234, 29);
        rd(0, 10'd5, 1, "R8 write refused while disabled");
        frame(0, 2'b00, 10'h300, 16'h0, 13);
        // R9 and R4: stored at a distinct address pattern
        frame(0, 2'b01, 10'h2A5, 16'h1234, 29);
        rd(0, 10'h2A5, 1, "R9 R4 write stored");
        // R10: erase one word
        frame(0, 2'b01, 10'd6, 16'hA5A5, 29);
        frame(0, 2'b11, 10'h2A5, 16'h0, 13);
        rd(0, 10'h2A5, 2, "R10 erase");
        // R12: short and long write frames do nothing
        frame(0, 2'b01, 10'd6, 16'h0F0F, 20);
        frame(0, 2'b01, 10'd6, 16'h0F0F, 30);
        frame(0, 2'b11, 10'd6, 16'h0, 14);
        rd(0, 10'd6, 1, "R12 miscounted frames ignored");
        // R3: dummy clocks before the start bit
        frame(5, 2'b01, 10'd7, 16'hBEEF, 29);
        rd(3, 10'd7, 1, "R3 dummy clocks");
        // R2: activity with select low has no effect
        for (int i = 0; i < 20; i++) begin
            di = 1'b1;
            clks(2);
            sk = ~sk;
            clks(2);
            check("R2 released while deselected", {31'd0, do_oe}, 32'd0);
        end
        sk = 1'b0;
        di = 1'b0;
        clks(3);
        rd(0, 10'd7, 1, "R2 frame after deselected noise");
        // R11: fill then erase all, with a miscounted fill first
        frame(0, 2'b00, 10'h100, 16'h5A5A, 28);
        rd(0, 10'd9, 1, "R12 short fill ignored");
        frame(0, 2'b00, 10'h100, 16'h5A5A, 29);
        rd(0, 10'd1023, 2, "R11 write all");
        frame(0, 2'b00, 10'h200, 16'h0, 13);
        rd(0, 10'd100, 1, "R11 erase all");
        // R8: disable then write refused
        frame(0, 2'b00, 10'h000, 16'h0, 13);
        frame(0, 2'b01, 10'd3, 16'h7777, 29);
        rd(0, 10'd3, 1, "R8 write refused after disable");

        // Seeded random frames
        for (int k = 0; k < 60; k++) begin
            kind = int'($urandom % 9);
            ra   = (k % 3 == 0) ? 10'($urandom) : 10'($urandom % 16);
            rdv  = 16'($urandom);
            n    = 0;
            case (kind)
                0, 1, 2: rd(int'($urandom % 4), ra, 1 + int'($urandom % 2), "R6 random read");
                3, 4: begin
                    n = ($urandom % 5 == 0) ? 28 + int'($urandom % 3) : 29;
                    frame(int'($urandom % 4), 2'b01, ra, rdv, n);
                end
                5: begin
                    n = ($urandom % 5 == 0) ? 12 + int'($urandom % 3) : 13;
                    frame(int'($urandom % 4), 2'b11, ra, rdv, n);
                end
                6: frame(0, 2'b00, {2'b11, ra[7:0]}, rdv, 13);
                7: frame(0, 2'b00, {2'b00, ra[7:0]}, rdv, 13);
                default: if (k % 20 == 8) frame(0, 2'b00, {2'b01, ra[7:0]}, rdv, 29);
            endcase
        end
        rd(0, 10'd0, 2, "R6 final read");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule